// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps effective addresses onto real addresses for large, aligned regions of memory. It holds four pairs of translation registers, each pair being an upper word (which region it covers, how large the region is, and in which privilege modes the pair is active) and a lower word (where the region lands in real memory and which access-rights code goes with it). One copy of the unit serves one access stream, either instruction fetch or data.

Software-side logic loads the words through a single-word write port. The lookup path is purely combinational. An effective address and the current privilege flag go in. In the same cycle the unit returns a hit flag, the real address and the 2-bit rights code of the winning pair. The rights code is only forwarded. Deciding whether an access is allowed is the caller's job, and so is falling back to page translation on a miss.

Block sizes start at 128 KB and double up to 256 MB. They are set by an 11-bit length field that widens the part of the address passed straight through. Bit numbers below count from the least significant bit (bit 0).

Top module: `bat_xlate`

## Requirements
- R1: After reset every pair reads as zero, so no pair is active: `hit` is 0, `realAddr` is 0 and `prot` is 0 for every address in both privilege modes.
- R2: A pair takes part in lookup only when its supervisor-enable bit (upper bit 1) is set while `probState` is 0, or its user-enable bit (upper bit 0) is set while `probState` is 1.
- R3: The upper word carries the region page index in bits 31:17 and the 11-bit length field in bits 12:2. The offset mask is that length field placed at bits 27:17, above ones in bits 16:0.
- R4: An active pair matches when the effective address with its offset-mask bits cleared equals the upper word with bits 16:0 cleared. If the page index has a bit set inside the mask, the pair can never match.
- R5: On a hit, `realAddr` equals the effective address ANDed with the offset mask, ORed with lower-word bits 31:17. Effective-address bits 16:0 therefore always pass through unchanged.
- R6: On a hit, `prot` equals bits 1:0 of the winning pair's lower word.
- R7: When several active pairs match, the one with the lowest index wins.
- R8: When no active pair matches, `hit` is 0 and both `realAddr` and `prot` are 0.
- R9: When `wrEn` is 1 at a rising clock edge, the word selected by `wrIdx` (pair number) and `wrUpper` (1 = upper, 0 = lower) takes `wrData`. Lookups see the new value from the cycle after that edge, and all other words keep their values.
- R10: A change of `probState` changes the set of active pairs and the lookup result in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register write port |
| rstN | input | 1 | Active-low synchronous reset of all pairs |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 2 | Pair number being written |
| wrUpper | input | 1 | 1 writes the upper word, 0 the lower word |
| wrData | input | 32 | Word to store |
| probState | input | 1 | 1 = problem (user) state, 0 = supervisor state |
| lookupEa | input | 32 | Effective address to translate |
| hit | output | 1 | An active pair covers the address |
| realAddr | output | 32 | Translated real address, 0 on a miss |
| prot | output | 2 | Rights code of the winning pair, 0 on a miss |

## Verification
The hardest case to reach is two active pairs covering the same address with different region sizes, where the winner flips when the privilege flag flips. The bench loads an overlapping small region at pair 0 (supervisor only) and a larger region at pair 3 (both modes). It then sweeps every page index with varied offsets in both modes, so both the priority rule and the mode gating are visited across whole region boundaries. A page index with a bit set under its own mask is loaded separately to show that such a pair stays silent. A write issued with a lookup pointing at its target checks the one-cycle latency of the register update.

// File: rtl/bat_pkg.sv
package bat_pkg;

  // Register format of one translation pair (bit 0 = least significant)
  localparam int WORD_W  = 32;
  localparam int OFFS_W  = 17;  // always-pass-through offset bits
  localparam int LEN_W   = 11;  // block length field width
  localparam int LEN_LSB = 2;   // length field position in the upper word
  localparam int VS_BIT  = 1;   // supervisor enable in the upper word
  localparam int VP_BIT  = 0;   // problem-state enable in the upper word
  localparam int PROT_W  = 2;   // rights code in lower word bits PROT_W-1:0

  // Strobes from control to one entry of the datapath
  typedef struct packed {
    logic loadUpper;
    logic loadLower;
    logic selVp;     // 1: gate on the problem-state enable bit
  } bat_strobe_t;

endpackage

// File: rtl/bat_ctrl.sv
module bat_ctrl
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrUpper,
  input  logic             probState,
  output bat_strobe_t      strobes [ENTRIES]
);

  // Decode the write port into one pair of load strobes per entry and
  // distribute the privilege selection to every entry.
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      strobes[i].loadUpper = wrEn &  wrUpper & (wrIdx == IDX_W'(i));
      strobes[i].loadLower = wrEn & ~wrUpper & (wrIdx == IDX_W'(i));
      strobes[i].selVp     = probState;
    end
  end

endmodule

// File: rtl/bat_entry.sv
module bat_entry
  import bat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bat_strobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] ea,
  output logic              matchOk,
  output logic [WORD_W-1:0] raOut,
  output logic [PROT_W-1:0] protOut
);

  localparam logic [WORD_W-1:0] LOW_MASK = WORD_W'({OFFS_W{1'b1}});

  logic [WORD_W-1:0] upperQ, lowerQ;
  logic [WORD_W-1:0] offMask;
  logic              enabled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      lowerQ <= '0;
    end else begin
      if (strobe.loadUpper) upperQ <= wrData;
      if (strobe.loadLower) lowerQ <= wrData;
    end
  end

  // Offset mask: length field directly above the fixed pass-through ones
  assign offMask = WORD_W'({upperQ[LEN_LSB +: LEN_W], {OFFS_W{1'b1}}});
  assign enabled = strobe.selVp ? upperQ[VP_BIT] : upperQ[VS_BIT];

  assign matchOk = enabled && ((ea & ~offMask) == (upperQ & ~LOW_MASK));
  assign raOut   = (ea & offMask) | (lowerQ & ~LOW_MASK);
  assign protOut = lowerQ[PROT_W-1:0];

  // R9
  load_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadUpper |=> (upperQ == $past(wrData)));

  // R9
  load_lower_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLower |=> (lowerQ == $past(wrData)));

  // R9
  hold_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadUpper && !strobe.loadLower) |=> ($stable(upperQ) && $stable(lowerQ)));

endmodule

// File: rtl/bat_pick.sv
module bat_pick
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [WORD_W-1:0]  raVec   [ENTRIES],
  input  logic [PROT_W-1:0]  protVec [ENTRIES],
  output logic               hit,
  output logic [WORD_W-1:0]  ra,
  output logic [PROT_W-1:0]  prot
);

  // Scan from the top index down so the lowest matching index is kept last
  always_comb begin
    hit  = 1'b0;
    ra   = '0;
    prot = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hit  = 1'b1;
        ra   = raVec[i];
        prot = protVec[i];
      end
    end
  end

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchVec[0] |-> (hit && ra == raVec[0] && prot == protVec[0]));

endmodule

// File: rtl/bat_datapath.sv
module bat_datapath
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bat_strobe_t       strobes [ENTRIES],
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] ea,
  output logic              hit,
  output logic [WORD_W-1:0] ra,
  output logic [PROT_W-1:0] prot
);

  logic [ENTRIES-1:0] matchVec;
  logic [WORD_W-1:0]  raVec   [ENTRIES];
  logic [PROT_W-1:0]  protVec [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    bat_entry uEntry (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobes[g]),
      .wrData  (wrData),
      .ea      (ea),
      .matchOk (matchVec[g]),
      .raOut   (raVec[g]),
      .protOut (protVec[g])
    );
  end

  bat_pick #(.ENTRIES(ENTRIES)) uPick (
    .clk      (clk),
    .rstN     (rstN),
    .matchVec (matchVec),
    .raVec    (raVec),
    .protVec  (protVec),
    .hit      (hit),
    .ra       (ra),
    .prot     (prot)
  );

endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrUpper,
  input  logic [WORD_W-1:0] wrData,
  input  logic              probState,
  input  logic [WORD_W-1:0] lookupEa,
  output logic              hit,
  output logic [WORD_W-1:0] realAddr,
  output logic [PROT_W-1:0] prot
);

  bat_strobe_t strobes [ENTRIES];

  bat_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrUpper   (wrUpper),
    .probState (probState),
    .strobes   (strobes)
  );

  bat_datapath #(.ENTRIES(ENTRIES)) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .ea      (lookupEa),
    .hit     (hit),
    .ra      (realAddr),
    .prot    (prot)
  );

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (realAddr[OFFS_W-1:0] == lookupEa[OFFS_W-1:0]));

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (realAddr == '0 && prot == '0));

endmodule

// File: tb/sim_bat_xlate.sv
`timescale 1ns/1ps
module sim_bat_xlate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrIdx = '0;
  logic        wrUpper = 1'b0;
  logic [31:0] wrData = '0;
  logic        probState = 1'b0;
  logic [31:0] lookupEa = '0;
  logic        hit;
  logic [31:0] realAddr;
  logic [1:0]  prot;

  int testsRun = 0;
  int testsFailed = 0;

  logic [31:0] shUp [4];
  logic [31:0] shLo [4];

  always #5 clk = ~clk;

  bat_xlate u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrUpper(wrUpper),
    .wrData(wrData), .probState(probState), .lookupEa(lookupEa),
    .hit(hit), .realAddr(realAddr), .prot(prot)
  );

  function automatic logic [31:0] mkUp(input logic [31:0] page, input logic [10:0] len,
                                       input logic vs, input logic vp);
    return (page & 32'hFFFE_0000) | (32'(len) << 2) | (32'(vs) << 1) | 32'(vp);
  endfunction

  // Expected lookup computed from R2..R8
  task automatic model(input logic [31:0] ea, input logic ps,
                       output logic eh, output logic [31:0] era, output logic [1:0] epp);
    eh = 1'b0; era = '0; epp = '0;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] m;
      logic en;
      m  = ((32'(shUp[i]) >> 2) & 32'h7FF) << 17 | 32'h1FFFF;
      en = ps ? shUp[i][0] : shUp[i][1];
      if (!eh && en && ((ea & ~m) == (shUp[i] & 32'hFFFE_0000))) begin
        eh = 1'b1;
        era = (ea & m) | (shLo[i] & 32'hFFFE_0000);
        epp = shLo[i][1:0];
      end
    end
  endtask

  task automatic cmp(input string tag, input logic eh, input logic [31:0] era,
                     input logic [1:0] epp);
    testsRun++;
    if (hit !== eh || realAddr !== era || prot !== epp) begin
      testsFailed++;
      $display("FAIL %s ea=%h ps=%0b: got hit=%0b ra=%h prot=%0d, expected hit=%0b ra=%h prot=%0d",
               tag, lookupEa, probState, hit, realAddr, prot, eh, era, epp);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] ea, input logic ps);
    logic eh; logic [31:0] era; logic [1:0] epp;
    lookupEa = ea; probState = ps;
    #1;
    model(ea, ps, eh, era, epp);
    cmp(tag, eh, era, epp);
  endtask

  task automatic lookFixed(input string tag, input logic [31:0] ea, input logic ps,
                           input logic eh, input logic [31:0] era, input logic [1:0] epp);
    lookupEa = ea; probState = ps;
    #1;
    cmp(tag, eh, era, epp);
  endtask

  task automatic wr(input int idx, input logic up, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 2'(idx); wrUpper = up; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (up) shUp[idx] = d; else shLo[idx] = d;
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 32768; p++) begin
      logic [31:0] ea;
      ea = {p[14:0], 17'((p * 32'h9E37) ^ (p << 3))};
      look(tag, ea, p[0]);
      look(tag, ea ^ 32'h0001_5A5A, ~p[0]);
    end
  endtask

  initial begin
    #2_000_000;
    testsFailed++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin shUp[i] = '0; shLo[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state: nothing active
    lookFixed("R1 reset", 32'h0000_0000, 1'b0, 1'b0, 32'h0, 2'd0);
    lookFixed("R1 reset", 32'h0000_0000, 1'b1, 1'b0, 32'h0, 2'd0);
    lookFixed("R1 reset", 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, 2'd0);
    lookFixed("R1 reset", 32'h8000_1234, 1'b1, 1'b0, 32'h0, 2'd0);

    // Overlapping configuration
    wr(0, 1'b1, mkUp(32'h1000_0000, 11'h000, 1'b1, 1'b0));
    wr(0, 1'b0, 32'hA000_0002);
    wr(1, 1'b1, mkUp(32'h2000_0000, 11'h00F, 1'b0, 1'b1));
    wr(1, 1'b0, 32'h4000_0001);
    wr(2, 1'b1, mkUp(32'h8000_0000, 11'h7FF, 1'b1, 1'b1));
    wr(2, 1'b0, 32'hC000_0003);
    wr(3, 1'b1, mkUp(32'h1000_0000, 11'h003, 1'b1, 1'b1));
    wr(3, 1'b0, 32'h5000_0000);

    // Fixed expectations, worked out by hand
    lookFixed("R7 R6 pair0 wins", 32'h1000_1234, 1'b0, 1'b1, 32'hA000_1234, 2'd2);
    lookFixed("R2 R7 pair3 in user", 32'h1000_1234, 1'b1, 1'b1, 32'h5000_1234, 2'd0);
    lookFixed("R3 512K region", 32'h1007_FFFF, 1'b0, 1'b1, 32'h5007_FFFF, 2'd0);
    lookFixed("R4 past region", 32'h1008_0000, 1'b0, 1'b0, 32'h0, 2'd0);
    lookFixed("R2 user-only pair in supervisor", 32'h2010_0000, 1'b0, 1'b0, 32'h0, 2'd0);
    lookFixed("R5 2MB region", 32'h2010_0000, 1'b1, 1'b1, 32'h4010_0000, 2'd1);
    lookFixed("R3 256MB region", 32'h8FFF_FFFC, 1'b1, 1'b1, 32'hCFFF_FFFC, 2'd3);
    lookFixed("R8 miss", 32'h7000_0000, 1'b0, 1'b0, 32'h0, 2'd0);

    // R10 privilege flip without clock
    lookFixed("R10 flip to user", 32'h1001_0000, 1'b1, 1'b1, 32'h5001_0000, 2'd0);
    lookFixed("R10 flip to supervisor", 32'h1001_0000, 1'b0, 1'b1, 32'hA001_0000, 2'd2);

    sweep("R2 R4 R5 R6 R7 R8 sweep");

    // R4 page index bit inside its own mask: pair 2 never matches
    wr(2, 1'b1, 32'h8010_0000 | (32'h7FF << 2) | 32'h3);
    lookFixed("R4 misaligned index", 32'h8010_0000, 1'b0, 1'b0, 32'h0, 2'd0);
    lookFixed("R4 misaligned index", 32'h8000_0000, 1'b1, 1'b0, 32'h0, 2'd0);
    sweep("R4 misaligned sweep");

    // R9 write latency: old value until the edge, new value after
    @(negedge clk);
    lookupEa = 32'h6000_0040; probState = 1'b0;
    wrEn = 1'b1; wrIdx = 2'd1; wrUpper = 1'b0; wrData = 32'h7000_0003;
    #1;
    lookFixed("R9 before edge", 32'h6000_0040, 1'b0, 1'b0, 32'h0, 2'd0);
    @(negedge clk);
    wrEn = 1'b0;
    shLo[1] = 32'h7000_0003;
    wr(1, 1'b1, mkUp(32'h6000_0000, 11'h000, 1'b1, 1'b0));
    lookFixed("R9 after edge", 32'h6000_0040, 1'b0, 1'b1, 32'h7000_0040, 2'd3);
    // R9 other pairs untouched
    lookFixed("R9 neighbour kept", 32'h1000_0010, 1'b0, 1'b1, 32'hA000_0010, 2'd2);
    lookFixed("R9 neighbour kept", 32'h1004_0010, 1'b1, 1'b1, 32'h5004_0010, 2'd0);
    // R2 pair with both enables cleared
    wr(3, 1'b1, mkUp(32'h1000_0000, 11'h003, 1'b0, 1'b0));
    lookFixed("R2 disabled pair", 32'h1004_0010, 1'b1, 1'b0, 32'h0, 2'd0);
    lookFixed("R2 disabled pair", 32'h1004_0010, 1'b0, 1'b0, 32'h0, 2'd0);
    sweep("R9 R2 final sweep");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule